// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block issues the multi-write command sequences that byte-wide parallel NOR flash devices expect. A single request names one operation: identifier read, sector erase, block erase, chip erase, write-protect enable or write-protect disable. The block then plays the matching series of bus writes. Every sequence opens with a fixed two-write unlock pair. Erase and protect-disable operations add a third write of 0x80 and a second unlock pair before their final command write. Software or a host controller only supplies the operation code and, for sector and block erase, the target base address.

Bus traffic goes out one beat at a time. The block holds `bus_valid` with address, data and direction until the bus side answers with `bus_ready`. Between writes it inserts waits whose cycle counts are derived from the `CLK_HZ` parameter. An identifier read enters identifier mode, waits for the device to settle and reads the manufacturer and device bytes. When a byte equals the continuation code 0x7F, it reads an extension byte as well. It then leaves identifier mode. After the final write of an erase, the block pulses a start to an external completion detector and stays busy until that detector reports done.

Top module: `flash_cmd_seq`

## Requirements
- R1: Every operation begins with a write of 0xAA to offset 0x5555, followed by a write of 0x55 to offset 0x2AAA.
- R2: Operation code 0 (identifier read) writes 0x90 to 0x5555 after the unlock pair. It then waits `CLK_HZ/100` cycles (10 ms) and reads offset 0, then offset 1. Next it writes the unlock pair and 0xF0 to 0x5555, stays busy for `CLK_HZ/25000` cycles (40 us) and then raises `id_valid`. The first unlock write of the exit follows the last read with no idle cycle.
- R3: A first-read byte of 0x7F triggers one extra read: offset 0x100 for the manufacturer and 0x101 for the device. These extra reads come after both first reads, manufacturer first. A continued identifier is {0x7F, extension byte}; any other identifier is {0x00, byte}.
- R4: While `id_valid` is high, `parity_warn` is high exactly when the low byte of `mfr_id` has an even number of one bits.
- R5: Operation codes 1 (sector erase), 2 (block erase) and 3 (chip erase) write six prefix beats: unlock pair, 0x80 to 0x5555, unlock pair. The final write is 0x30 to `req_addr` for sector erase, 0x50 to `req_addr` for block erase, and 0x10 to 0x5555 for chip erase.
- R6: Operation code 4 (protect enable) writes the unlock pair and then 0xA0 to 0x5555. Operation code 5 (protect disable) writes the six-beat prefix and then 0x20 to 0x5555. Both place their writes back to back with no idle cycle and stay busy for `CLK_HZ/5000` cycles (200 us) after the last write.
- R7: During identifier-read and erase operations, consecutive command writes are separated by exactly `CLK_HZ/100000` idle cycles (10 us).
- R8: One cycle after the final erase write is accepted, `det_start` is high for exactly one cycle. `busy` then stays high until the cycle in which `det_done` is sampled high. `det_done` has no effect while the erase writes are still being issued.
- R9: A beat stays on the bus with unchanged address, data and direction until `bus_ready` is sampled high. Reads use only offsets 0, 1, 0x100 and 0x101.
- R10: After reset the block is idle: `req_ready` high, `busy`, `bus_valid` and `id_valid` low. Requests are taken only while `req_ready` is high. Operation codes 6 and 7 are ignored and produce no bus beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request, sampled while req_ready is high |
| req_op | input | 3 | Operation code (0 id, 1 sector, 2 block, 3 chip, 4 protect on, 5 protect off) |
| req_addr | input | AW | Base address for sector and block erase |
| req_ready | output | 1 | Idle and ready for a request |
| busy | output | 1 | An operation is in progress |
| bus_valid | output | 1 | A bus beat is offered |
| bus_we | output | 1 | Beat is a write (1) or a read (0) |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | 8 | Write data |
| bus_ready | input | 1 | Beat accepted this cycle; read data valid |
| bus_rdata | input | 8 | Read data |
| det_start | output | 1 | One-cycle start to the completion detector |
| det_done | input | 1 | Completion detector reports done |
| id_valid | output | 1 | Identifier outputs hold a completed read |
| mfr_id | output | 16 | Manufacturer identifier |
| dev_id | output | 16 | Device identifier |
| parity_warn | output | 1 | Manufacturer byte fails odd parity |

## Verification
The bench builds the block with `AW` = 16 and `CLK_HZ` = 1 MHz. This scales the waits to 10, 10000, 40 and 200 cycles, so every interval can be counted cycle by cycle in a short run. It sweeps every operation code, including both unused codes, and several sector and block base addresses. It also covers all four combinations of continued and plain identifier bytes, with both parity outcomes. The bus side can stall each beat, and a spurious detector done is injected during an erase prefix.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [2:0] {
      OP_ID       = 3'd0,
      OP_SECT     = 3'd1,
      OP_BLK      = 3'd2,
      OP_CHIP     = 3'd3,
      OP_PROT_ON  = 3'd4,
      OP_PROT_OFF = 3'd5
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_WR, S_WAIT, S_RD, S_DET
   } st_e;

   typedef enum logic [1:0] {
      N_WR, N_RD, N_DONE
   } nxt_e;

   localparam logic [15:0] ADR_A     = 16'h5555;
   localparam logic [15:0] ADR_B     = 16'h2AAA;
   localparam logic [7:0]  CONT_CODE = 8'h7F;

endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table
   import flash_seq_pkg::*;
#(
   parameter int AW = 18
) (
   input  op_e           op,
   input  logic          exit_ph,
   input  logic [2:0]    idx,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] addr,
   output logic [7:0]    data,
   output logic          last
);

   always_comb begin
      addr = AW'(ADR_A);
      data = 8'hFF;
      last = 1'b0;
      case (idx)
         3'd0: data = 8'hAA;
         3'd1: begin addr = AW'(ADR_B); data = 8'h55; end
         3'd2: begin
            if (op == OP_ID) begin
               data = exit_ph ? 8'hF0 : 8'h90;
               last = 1'b1;
            end else if (op == OP_PROT_ON) begin
               data = 8'hA0;
               last = 1'b1;
            end else begin
               data = 8'h80;
            end
         end
         3'd3: data = 8'hAA;
         3'd4: begin addr = AW'(ADR_B); data = 8'h55; end
         3'd5: begin
            last = 1'b1;
            case (op)
               OP_CHIP: data = 8'h10;
               OP_SECT: begin addr = base; data = 8'h30; end
               OP_BLK:  begin addr = base; data = 8'h50; end
               default: data = 8'h20;
            endcase
         end
         default: last = 1'b1;
      endcase
   end

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/flash_id_slot.sv
module flash_id_slot
   import flash_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        cap_first,
   input  logic        cap_second,
   input  logic [7:0]  din,
   output logic [15:0] id,
   output logic        cont
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id   <= '0;
         cont <= 1'b0;
      end else if (clr) begin
         id   <= '0;
         cont <= 1'b0;
      end else if (cap_first) begin
         id   <= {8'h00, din};
         cont <= (din == CONT_CODE);
      end else if (cap_second) begin
         id   <= {id[7:0], din};
      end
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int AW     = 18,
   parameter int CLK_HZ = 50_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          busy,
   output logic          bus_valid,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [7:0]    bus_wdata,
   input  logic          bus_ready,
   input  logic [7:0]    bus_rdata,
   output logic          det_start,
   input  logic          det_done,
   output logic          id_valid,
   output logic [15:0]   mfr_id,
   output logic [15:0]   dev_id,
   output logic          parity_warn
);

   localparam int GAP_CYC    = (CLK_HZ / 100_000 > 0) ? CLK_HZ / 100_000 : 1;
   localparam int SETTLE_CYC = (CLK_HZ / 100 > 0)     ? CLK_HZ / 100     : 1;
   localparam int EXIT_CYC   = (CLK_HZ / 25_000 > 0)  ? CLK_HZ / 25_000  : 1;
   localparam int PROT_CYC   = (CLK_HZ / 5_000 > 0)   ? CLK_HZ / 5_000   : 1;
   localparam int TW         = $clog2(SETTLE_CYC + 1);

   if (AW < 16) begin : g_bad_aw
      $error("flash_cmd_seq: AW must cover the 16-bit command offsets");
   end
   if (CLK_HZ < 100_000) begin : g_bad_clk
      $error("flash_cmd_seq: CLK_HZ too low for the inter-write spacing");
   end

   st_e           state;
   nxt_e          nxt_q;
   op_e           op_q;
   logic [AW-1:0] base_q;
   logic          exit_q;
   logic [2:0]    idx_q;
   logic [1:0]    rd_q;
   logic          det_q;
   logic          idv_q;

   logic [AW-1:0] t_addr;
   logic [7:0]    t_data;
   logic          t_last;
   logic [AW-1:0] rd_addr;
   logic          acc, wr_acc, rd_acc, is_prot, op_ok, id_clr;
   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic [1:0]    rd_next;
   logic          rd_more;
   logic [15:0]   slot_id [2];
   logic [1:0]    slot_cont;

   flash_seq_table #(.AW(AW)) u_table (
      .op(op_q), .exit_ph(exit_q), .idx(idx_q), .base(base_q),
      .addr(t_addr), .data(t_data), .last(t_last)
   );

   flash_seq_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   assign acc     = bus_valid && bus_ready;
   assign wr_acc  = (state == S_WR) && acc;
   assign rd_acc  = (state == S_RD) && acc;
   assign is_prot = (op_q == OP_PROT_ON) || (op_q == OP_PROT_OFF);
   assign op_ok   = (req_op <= 3'd5);
   assign id_clr  = (state == S_IDLE) && req_valid && (req_op == OP_ID);

   for (genvar i = 0; i < 2; i++) begin : g_slot
      flash_id_slot u_slot (
         .clk(clk), .rst_n(rst_n), .clr(id_clr),
         .cap_first(rd_acc && (rd_q == 2'(i))),
         .cap_second(rd_acc && (rd_q == 2'(i + 2))),
         .din(bus_rdata), .id(slot_id[i]), .cont(slot_cont[i])
      );
   end

   always_comb begin
      case (rd_q)
         2'd0:    rd_addr = AW'(16'h0000);
         2'd1:    rd_addr = AW'(16'h0001);
         2'd2:    rd_addr = AW'(16'h0100);
         default: rd_addr = AW'(16'h0101);
      endcase
   end

   always_comb begin
      rd_next = rd_q + 2'd1;
      rd_more = 1'b1;
      case (rd_q)
         2'd0: rd_next = 2'd1;
         2'd1: begin
            if (slot_cont[0])                rd_next = 2'd2;
            else if (bus_rdata == CONT_CODE) rd_next = 2'd3;
            else                             rd_more = 1'b0;
         end
         2'd2: begin
            if (slot_cont[1]) rd_next = 2'd3;
            else              rd_more = 1'b0;
         end
         default: rd_more = 1'b0;
      endcase
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (wr_acc) begin
         if (!t_last) begin
            tmr_load = !is_prot;
            tmr_val  = TW'(GAP_CYC - 1);
         end else if (op_q == OP_ID) begin
            tmr_load = 1'b1;
            tmr_val  = exit_q ? TW'(EXIT_CYC - 1) : TW'(SETTLE_CYC - 1);
         end else if (is_prot) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(PROT_CYC - 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         nxt_q  <= N_WR;
         op_q   <= OP_ID;
         base_q <= '0;
         exit_q <= 1'b0;
         idx_q  <= '0;
         rd_q   <= '0;
         det_q  <= 1'b0;
         idv_q  <= 1'b0;
      end else begin
         det_q <= 1'b0;
         case (state)
            S_IDLE: if (req_valid && op_ok) begin
               op_q   <= op_e'(req_op);
               base_q <= req_addr;
               exit_q <= 1'b0;
               idx_q  <= '0;
               rd_q   <= '0;
               state  <= S_WR;
               if (req_op == OP_ID) idv_q <= 1'b0;
            end
            S_WR: if (acc) begin
               if (!t_last) begin
                  idx_q <= idx_q + 3'd1;
                  nxt_q <= N_WR;
                  state <= is_prot ? S_WR : S_WAIT;
               end else begin
                  idx_q <= '0;
                  if (op_q == OP_ID) begin
                     nxt_q <= exit_q ? N_DONE : N_RD;
                     state <= S_WAIT;
                  end else if (is_prot) begin
                     nxt_q <= N_DONE;
                     state <= S_WAIT;
                  end else begin
                     det_q <= 1'b1;
                     state <= S_DET;
                  end
               end
            end
            S_WAIT: if (tmr_zero) begin
               case (nxt_q)
                  N_WR:    state <= S_WR;
                  N_RD:    state <= S_RD;
                  default: begin
                     state <= S_IDLE;
                     if (op_q == OP_ID) idv_q <= 1'b1;
                  end
               endcase
            end
            S_RD: if (acc) begin
               if (rd_more) begin
                  rd_q <= rd_next;
               end else begin
                  exit_q <= 1'b1;
                  idx_q  <= '0;
                  state  <= S_WR;
               end
            end
            S_DET: if (det_done) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (state == S_IDLE);
   assign busy        = (state != S_IDLE);
   assign bus_valid   = (state == S_WR) || (state == S_RD);
   assign bus_we      = (state == S_WR);
   assign bus_addr    = (state == S_WR) ? t_addr : rd_addr;
   assign bus_wdata   = (state == S_WR) ? t_data : 8'h00;
   assign det_start   = det_q;
   assign id_valid    = idv_q;
   assign mfr_id      = slot_id[0];
   assign dev_id      = slot_id[1];
   assign parity_warn = idv_q && !(^slot_id[0][7:0]);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
   parameter int AW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          busy,
   input logic          bus_valid,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [7:0]    bus_wdata,
   input logic          bus_ready,
   input logic          det_start
);

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R9

   AST_READ_OFFSETS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_we |-> (bus_addr == AW'(16'h0000) || bus_addr == AW'(16'h0001) ||
                                bus_addr == AW'(16'h0100) || bus_addr == AW'(16'h0101))); // R9

   AST_UNLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> bus_valid && bus_we && bus_addr == AW'(16'h5555) && bus_wdata == 8'hAA); // R1

   AST_DET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      det_start |=> !det_start); // R8

   AST_DET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      det_start |-> busy && !bus_valid); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_valid && !busy); // R10

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
   .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_ready(bus_ready), .det_start(det_start)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

   localparam int AW      = 16;
   localparam int CLK_HZ  = 1_000_000;
   localparam int GAP     = CLK_HZ / 100_000;
   localparam int SETTLE  = CLK_HZ / 100;
   localparam int EXITW   = CLK_HZ / 25_000;
   localparam int PROTW   = CLK_HZ / 5_000;
   localparam int DET_LAT = 25;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, busy, bus_valid, bus_we;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata;
   logic          bus_ready = 1'b0;
   logic [7:0]    bus_rdata = 8'hFF;
   logic          det_start;
   logic          det_done = 1'b0;
   logic          id_valid, parity_warn;
   logic [15:0]   mfr_id, dev_id;

   flash_cmd_seq #(.AW(AW), .CLK_HZ(CLK_HZ)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_ready(req_ready), .busy(busy),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .det_start(det_start), .det_done(det_done), .id_valid(id_valid),
      .mfr_id(mfr_id), .dev_id(dev_id), .parity_warn(parity_warn)
   );

   always #10 clk = ~clk;

   int  checks = 0;
   int  fails = 0;
   bit  finished = 0;

   logic [7:0] m1 = 8'h00, d1 = 8'h00, m2 = 8'h00, d2 = 8'h00;
   int  n = 0, idle_run = 0, tail_run = 0, stall_cfg = 0, stall_left = 0;
   int  det_wait = -1, det_cyc_cnt = 0, ds_cyc = 0, rise_cyc = 0, cyc = 0;
   bit  prev_ready = 1'b1;
   bit  spur_arm = 1'b0;
   int  spur_beat = 0;
   logic [24:0] log_beat [16];
   int          log_idle [16];
   logic [24:0] exp_beat [16];
   int          exp_idle [16];
   int          ne = 0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // flash-side model: bus response, read data, completion detector
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         det_done = 1'b0;
         if (det_wait == 0) begin
            det_done = 1'b1;
            det_wait = -1;
         end else if (det_wait > 0) begin
            det_wait--;
         end
         if (spur_arm && n == spur_beat && !bus_valid) begin
            det_done = 1'b1;
            spur_arm = 1'b0;
         end
         if (det_start) begin
            det_wait = DET_LAT;
            det_cyc_cnt++;
            ds_cyc = cyc;
         end
         if (req_ready && !prev_ready) rise_cyc = cyc;
         prev_ready = req_ready;
         case (bus_addr)
            16'h0000: bus_rdata = m1;
            16'h0001: bus_rdata = d1;
            16'h0100: bus_rdata = m2;
            16'h0101: bus_rdata = d2;
            default:  bus_rdata = 8'hFF;
         endcase
         bus_ready = 1'b0;
         if (bus_valid) begin
            if (stall_left > 0) begin
               stall_left--;
            end else begin
               bus_ready  = 1'b1;
               stall_left = stall_cfg;
               if (n < 16) begin
                  log_beat[n] = {bus_we, bus_addr, bus_we ? bus_wdata : 8'h00};
                  log_idle[n] = idle_run;
               end
               n++;
               idle_run = 0;
               tail_run = 0;
            end
         end else begin
            idle_run++;
            if (busy) tail_run++;
         end
      end
   end

   task automatic push(input bit we, input logic [15:0] a, input logic [7:0] d, input int idl);
      exp_beat[ne] = {we, a, we ? d : 8'h00};
      exp_idle[ne] = idl;
      ne++;
   endtask

   task automatic build_exp(input int op, input logic [15:0] base);
      int g;
      ne = 0;
      g  = (op == 4 || op == 5) ? 0 : GAP;
      push(1'b1, 16'h5555, 8'hAA, -1);
      push(1'b1, 16'h2AAA, 8'h55, g);
      if (op == 0) begin
         push(1'b1, 16'h5555, 8'h90, GAP);
         push(1'b0, 16'h0000, 8'h00, SETTLE);
         push(1'b0, 16'h0001, 8'h00, 0);
         if (m1 == 8'h7F) push(1'b0, 16'h0100, 8'h00, 0);
         if (d1 == 8'h7F) push(1'b0, 16'h0101, 8'h00, 0);
         push(1'b1, 16'h5555, 8'hAA, 0);
         push(1'b1, 16'h2AAA, 8'h55, GAP);
         push(1'b1, 16'h5555, 8'hF0, GAP);
      end else if (op == 4) begin
         push(1'b1, 16'h5555, 8'hA0, 0);
      end else begin
         push(1'b1, 16'h5555, 8'h80, g);
         push(1'b1, 16'h5555, 8'hAA, g);
         push(1'b1, 16'h2AAA, 8'h55, g);
         case (op)
            1:       push(1'b1, base,     8'h30, g);
            2:       push(1'b1, base,     8'h50, g);
            3:       push(1'b1, 16'h5555, 8'h10, g);
            default: push(1'b1, 16'h5555, 8'h20, g);
         endcase
      end
   endtask

   task automatic send(input int op, input logic [15:0] base);
      @(negedge clk);
      n          = 0;
      idle_run   = 0;
      tail_run   = 0;
      stall_left = stall_cfg;
      req_valid  = 1'b1;
      req_op     = op[2:0];
      req_addr   = base;
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!req_ready);
   endtask

   task automatic run_op(input int op, input logic [15:0] base, input string tag);
      string itag;
      itag = (op == 4 || op == 5) ? "R6" : "R7";
      build_exp(op, base);
      send(op, base);
      wait_idle();
      chk(n == ne, tag, "beat count", n, ne);
      for (int i = 0; i < ne && i < n && i < 16; i++) begin
         chk(log_beat[i] == exp_beat[i], (i < 2) ? "R1" : tag,
             $sformatf("beat %0d {we,addr,data}", i), int'(log_beat[i]), int'(exp_beat[i]));
         if (exp_idle[i] >= 0)
            chk(log_idle[i] == exp_idle[i], itag, $sformatf("idle cycles before beat %0d", i),
                log_idle[i], exp_idle[i]);
      end
   endtask

   logic [7:0] pm1 [4] = '{8'h01, 8'h7F, 8'h03, 8'h7F};
   logic [7:0] pd1 [4] = '{8'h21, 8'hB5, 8'h7F, 8'h7F};
   logic [7:0] pm2 [4] = '{8'hEE, 8'h1F, 8'hEE, 8'h00};
   logic [7:0] pd2 [4] = '{8'hEE, 8'hEE, 8'h9C, 8'h42};

   initial begin
      logic [15:0] em, ed, base;
      bit ew;
      repeat (5) @(negedge clk);
      chk(req_ready == 1'b1, "R10", "req_ready in reset", req_ready, 1);
      chk(busy == 1'b0 && bus_valid == 1'b0, "R10", "busy/bus_valid in reset", {busy, bus_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !busy && !bus_valid && !id_valid && !det_start, "R10", "idle after reset",
          {req_ready, busy, bus_valid, id_valid, det_start}, 5'b10000);

      // identifier reads: plain and continued bytes, both parity outcomes
      for (int p = 0; p < 4; p++) begin
         m1 = pm1[p]; d1 = pd1[p]; m2 = pm2[p]; d2 = pd2[p];
         run_op(0, 16'h0000, "R2");
         em = (m1 == 8'h7F) ? {8'h7F, m2} : {8'h00, m1};
         ed = (d1 == 8'h7F) ? {8'h7F, d2} : {8'h00, d1};
         ew = ((($countones(em[7:0])) % 2) == 0);
         chk(id_valid == 1'b1, "R2", "id_valid after identifier read", id_valid, 1);
         chk(tail_run == EXITW, "R2", "busy cycles after exit write", tail_run, EXITW);
         chk(mfr_id == em, "R3", "manufacturer identifier", mfr_id, em);
         chk(dev_id == ed, "R3", "device identifier", dev_id, ed);
         chk(parity_warn == ew, "R4", "parity warning", parity_warn, ew);
      end

      // sector and block erase over several base addresses
      for (int k = 0; k < 4; k++) begin
         for (int op = 1; op <= 2; op++) begin
            base = 16'(k * 16'h4000 + k * 16'h0123);
            det_cyc_cnt = 0;
            run_op(op, base, "R5");
            chk(det_cyc_cnt == 1, "R8", "det_start high cycles", det_cyc_cnt, 1);
            chk(rise_cyc == ds_cyc + DET_LAT + 2, "R8", "release after det_done",
                rise_cyc, ds_cyc + DET_LAT + 2);
         end
      end

      // chip erase ignores the request address
      det_cyc_cnt = 0;
      run_op(3, 16'hABCD, "R5");
      chk(det_cyc_cnt == 1, "R8", "det_start high cycles on chip erase", det_cyc_cnt, 1);

      // spurious detector done during the erase prefix
      det_cyc_cnt = 0;
      spur_arm  = 1'b1;
      spur_beat = 2;
      run_op(2, 16'h8000, "R8");
      chk(det_cyc_cnt == 1, "R8", "det_start after early det_done", det_cyc_cnt, 1);
      chk(rise_cyc == ds_cyc + DET_LAT + 2, "R8", "release after early det_done",
          rise_cyc, ds_cyc + DET_LAT + 2);

      // protect enable and disable
      run_op(4, 16'h0000, "R6");
      chk(tail_run == PROTW, "R6", "busy cycles after protect enable", tail_run, PROTW);
      run_op(5, 16'h0000, "R6");
      chk(tail_run == PROTW, "R6", "busy cycles after protect disable", tail_run, PROTW);

      // stalled bus: beats held until accepted
      stall_cfg = 3;
      run_op(5, 16'h0000, "R9");
      run_op(3, 16'h0000, "R9");
      stall_cfg = 0;

      // undefined operation codes
      for (int op = 6; op <= 7; op++) begin
         send(op, 16'h1234);
         repeat (30) @(negedge clk);
         chk(n == 0, "R10", $sformatf("beats for op %0d", op), n, 0);
         chk(req_ready && !busy, "R10", $sformatf("idle after op %0d", op), {req_ready, busy}, 2'b10);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule